// File: doc/BRIEF.md
# Sampled Tick Counter Extender

This block turns a free-running 32-bit tick counter into a 64-bit timestamp without any overflow interrupt. The counter advances by one on every cycle in which the tick enable is high. A host can also load it directly, for instance to trim it against an external time reference. A periodic sample strobe, unrelated to the tick rate, copies the live counter into a stored low snapshot. When the copy is smaller than the snapshot it replaces, the block concludes that the counter has wrapped and adds one to a stored high word.

A read request returns a 64-bit value. That value is the stored high word joined with the snapshot, plus the live counter minus the snapshot, with the 32-bit difference taken as signed. A slightly retarded counter therefore yields a slightly earlier time rather than a leap of about 49.7 days. The result is registered and arrives one cycle after the request, with a one-cycle valid pulse. The sample strobe must come much more often than the 2^32-tick wrap period and much less often than one tick.

Top module: `tick_extender`

## Requirements
- R1: After reset the live counter, stored high word and low snapshot are all zero, ts_vld is low and ts_out is zero.
- R2: With adj_en low, every cycle with tick_en high adds one to the live counter, which wraps from 0xFFFF_FFFF to 0x0000_0000.
- R3: adj_en loads adj_val into the live counter and overrides tick_en in that cycle.
- R4: On samp_stb, if the snapshot is greater than the live counter, the stored high word increases by exactly one.
- R5: On samp_stb the snapshot takes the live counter value; when the snapshot is not greater, the high word is unchanged; with no samp_stb neither stored word changes. The first sample after reset never counts as a wrap.
- R6: On rd_req, ts_out becomes {high, snapshot} plus the sign-extended 32-bit difference (live counter minus snapshot), so a read across an unsampled wrap is still correct.
- R7: A live counter below the snapshot by less than 2^31 gives a result below {high, snapshot} by that amount.
- R8: When rd_req and samp_stb occur in the same cycle, the read uses the high word and snapshot held before that sample.
- R9: ts_vld is high exactly in the cycle after each rd_req cycle, and ts_out holds its value in every cycle that follows a cycle without rd_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance the live counter by one |
| adj_en | input | 1 | Load the live counter from adj_val |
| adj_val | input | 32 | Value loaded into the live counter |
| samp_stb | input | 1 | Capture the live counter and detect a wrap |
| rd_req | input | 1 | Request a 64-bit timestamp |
| ts_out | output | 64 | Registered timestamp |
| ts_vld | output | 1 | One-cycle pulse marking a new timestamp |

## Verification
The wrap rule is only sound if at most one wrap happens between samples. A load that moves the counter backward, followed by a sample, is indistinguishable from a wrap. The assertions therefore only check single-step changes of the high word and make no claim about true elapsed time. The stimulus reaches the wrap through loads near the top of the counter range, not through 2^32 ticks. Its random phase accepts that a backward load may be counted as a wrap: the reference model follows the same comparison rule, so the results still match.

// File: rtl/tick_extender.sv
module tick_extender #(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 adj_en,
  input  logic [CNT_W-1:0]     adj_val,
  input  logic                 samp_stb,
  input  logic                 rd_req,
  output logic [2*CNT_W-1:0]   ts_out,
  output logic                 ts_vld
);
  localparam int TS_W = 2 * CNT_W;

  logic [CNT_W-1:0] cnt, lo, hi, delta;
  logic [TS_W-1:0]  delta_x, base, sum;

  assign delta   = cnt - lo;
  assign delta_x = {{CNT_W{delta[CNT_W-1]}}, delta};
  assign base    = {hi, lo};
  assign sum     = base + delta_x;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (adj_en)  cnt <= adj_val;
    else if (tick_en) cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (samp_stb) begin
      lo <= cnt;
      if (lo > cnt) hi <= hi + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ts_out <= '0;
      ts_vld <= 1'b0;
    end else begin
      ts_vld <= rd_req;
      if (rd_req) ts_out <= sum;
    end

  p_cnt_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_en && tick_en) |=> cnt == $past(cnt) + 1'b1);
  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_en && !tick_en) |=> $stable(cnt));
  p_cnt_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adj_en |=> cnt == $past(adj_val));
  p_hi_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |=> (hi == $past(hi) || hi == $past(hi) + 1'b1));
  p_lo_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |=> lo == $past(cnt));
  p_words_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_stb |=> ($stable(hi) && $stable(lo)));
  p_vld_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> ts_vld);
  p_vld_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!ts_vld && $stable(ts_out)));
endmodule

// File: tb/tb_tick_extender.sv
module tb_tick_extender;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, adj_en = 1'b0, samp_stb = 1'b0, rd_req = 1'b0;
  logic [31:0] adj_val = '0;
  logic [63:0] ts_out;
  logic        ts_vld;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_extender dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .adj_en(adj_en),
    .adj_val(adj_val), .samp_stb(samp_stb), .rd_req(rd_req),
    .ts_out(ts_out), .ts_vld(ts_vld));

  // reference model
  bit [31:0] m_cnt, m_lo, m_hi;
  bit [63:0] m_ts;
  bit        m_vld;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lo = 0; m_hi = 0; m_ts = 0; m_vld = 0;
    end else begin
      int d;
      bit [31:0] c_old;
      c_old = m_cnt;
      d = int'(m_cnt - m_lo);
      m_vld = rd_req;
      if (rd_req) m_ts = {m_hi, m_lo} + 64'(longint'(d));
      if (samp_stb) begin
        if (m_lo > c_old) m_hi = m_hi + 1;
        m_lo = c_old;
      end
      if (adj_en) m_cnt = adj_val;
      else if (tick_en) m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    n_cmp++;
    if (ts_vld !== m_vld) begin
      n_bad++;
      $display("FAIL R9 ts_vld actual %0b expected %0b", ts_vld, m_vld);
    end else if (ts_out !== m_ts) begin
      n_bad++;
      $display("FAIL R6 ts_out actual %h expected %h", ts_out, m_ts);
    end
  end

  task automatic check(string tag, logic [63:0] exp_ts, logic exp_v);
    n_cmp++;
    if (ts_out !== exp_ts || ts_vld !== exp_v) begin
      n_bad++;
      $display("FAIL %s ts_out/vld actual %h/%0b expected %h/%0b", tag, ts_out, ts_vld, exp_ts, exp_v);
    end
  endtask

  task automatic step(bit tk, bit sp, bit rd, bit ad = 0, logic [31:0] v = 0);
    tick_en = tk; samp_stb = sp; rd_req = rd; adj_en = ad; adj_val = v;
    @(negedge clk);
    tick_en = 0; samp_stb = 0; rd_req = 0; adj_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 64'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 1);                    check("R1", 64'h0, 1'b1);
    for (int i = 0; i < 10; i++) step(1, 0, 0);
    check("R9", 64'h0, 1'b0);
    step(0, 0, 1);                    check("R2", 64'd10, 1'b1);
    step(0, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    step(0, 0, 1);                    check("R5", 64'd15, 1'b1);
    step(1, 0, 0, 1, 32'hFFFF_FFF0);
    step(0, 1, 0);
    step(0, 0, 1);                    check("R3", 64'h0000_0000_FFFF_FFF0, 1'b1);
    for (int i = 0; i < 32; i++) step(1, 0, 0);
    step(0, 0, 1);                    check("R6", 64'h0000_0001_0000_0010, 1'b1);
    step(0, 1, 0);
    step(0, 0, 1);                    check("R4", 64'h0000_0001_0000_0010, 1'b1);
    step(0, 1, 0);
    step(0, 0, 1);                    check("R5", 64'h0000_0001_0000_0010, 1'b1);
    step(0, 0, 0, 1, 32'h0000_000B);
    step(0, 0, 1);                    check("R7", 64'h0000_0001_0000_000B, 1'b1);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(0, 1, 1);                    check("R8", 64'h0000_0001_0000_000E, 1'b1);
    step(0, 0, 1);                    check("R4", 64'h0000_0002_0000_000E, 1'b1);
    step(0, 0, 0);                    check("R9", 64'h0000_0002_0000_000E, 1'b0);
    for (int i = 0; i < 4000; i++) begin
      bit ad = ($urandom_range(0, 199) == 0);
      step($urandom_range(0, 1) == 1, $urandom_range(0, 15) == 0,
           $urandom_range(0, 3) == 0, ad, $urandom());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule